// File: doc/BRIEF.md
# IR Pulse-Length Capture Engine

This block receives the demodulated output of an infrared remote-control receiver. It records the line as a series of level runs and does not decode any protocol. The input is brought into the clock domain and then sampled on a programmable tick. Short excursions are filtered out. Each stable run of high or low is measured in ticks and written to a byte buffer as one entry. An entry carries the run level in bit 7 and the length in bits 6:0. A capture starts on the first pulse after the block is armed. It ends when one of three things happens: the line has been low for the idle length, the total capture time reaches the maximum duration, or the buffer fills.

Software reaches the block through a byte-wide register port. On completion it reads the flag register and expects 0x83 (0x87 if the buffer filled). It then reads the entry count and the entries from the buffer window. To re-arm, it writes the flag register to clear the status, clears the buffer, and sets the enable bit again. The host converts run lengths into time; with the intended prescaler setting one unit stands for 50.8 µs.

Top module: `ir_pulse_capture`

## Requirements
- R1: An entry is {level, length}: bit 7 = 1 for a high (pulse) run, bits 6:0 = run length in sample ticks. The idle line level is 0. An armed engine starts at the first tick on which the filtered line is 1, and entries are written in line order starting at buffer index 0.
- R2: A run longer than 127 ticks writes an entry of length 127 and continues counting from 1 in a new entry with the same level bit.
- R3: A change of the sampled line is accepted only after it has differed from the filtered level for G consecutive ticks, where G is the glitch register (offset 0x04, reset 3) and a value of 0 acts as 1. Shorter excursions merge into the surrounding run.
- R4: A capture ends when the filtered line has been 0 for IDLE consecutive ticks. IDLE is 16 bits, low byte at 0x05 and high byte at 0x06. The run still open at that point is not stored.
- R5: A capture ends when the number of ticks since it started reaches MAXD. MAXD is 16 bits, low byte at 0x07 and high byte at 0x08. The open run is not stored.
- R6: The write that brings the count to DEPTH ends the capture and sets the overflow flag. The count never exceeds DEPTH.
- R7: The flag register at 0x00 has these bits: bit 0 = capture complete; bit 1 = buffer non-empty at completion; bit 2 = overflow; bit 7 = enable (read only). Bits 2:0 are cleared by writing 1. A normal completion reads 0x83.
- R8: Writing bit 7 = 1 to 0x02 clears the count and write pointer. Writing 0x01 with bit 7 = 1 arms a new capture, and writing 0 to 0x01 stops capture.
- R9: The configuration registers read back what was written. Their reset values are: glitch 3, idle 0x00C0, maximum 0x07D0, high tolerance (0x09) 0x1E, low tolerance (0x0A) 0x1E, prescaler (0x0B) PRESCALE_RESET.
- R10: With prescaler value D, a sample tick occurs every D+1 clocks, so run lengths scale with D+1.
- R11: The count register at 0x03 reports the number of valid entries. Address 0x80+i reads entry i, and reads 0 for i ≥ DEPTH.
- R12: After reset the flag register reads 0x00 and the count reads 0, and no capture occurs until the engine is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated IR line, 1 = carrier present |
| reg_addr_i | input | 8 | Register address; bit 7 selects the buffer window |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |

## Verification
The bench builds the block with DEPTH = 16 and PRESCALE_RESET = 1. The small buffer lets a train of short runs reach the overflow end in a few hundred ticks. The two-clock tick exercises the prescaler from reset, and a later rewrite to four clocks exercises it again. With these values the saturation split, glitch merging, idle and maximum-duration endings, and the full re-arm handshake all fit in a short run. A behavioural tick model derives every entry independently of the RTL.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;
  localparam int unsigned ENTRY_W = 8;
  localparam int unsigned LEN_W   = 7;
  localparam int unsigned DUR_W   = 16;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  localparam logic [4:0] OFS_FLAG   = 5'h00;
  localparam logic [4:0] OFS_RXCTL  = 5'h01;
  localparam logic [4:0] OFS_BUFCTL = 5'h02;
  localparam logic [4:0] OFS_COUNT  = 5'h03;
  localparam logic [4:0] OFS_GLITCH = 5'h04;
  localparam logic [4:0] OFS_IDLE_L = 5'h05;
  localparam logic [4:0] OFS_IDLE_H = 5'h06;
  localparam logic [4:0] OFS_MAXD_L = 5'h07;
  localparam logic [4:0] OFS_MAXD_H = 5'h08;
  localparam logic [4:0] OFS_TOL_HI = 5'h09;
  localparam logic [4:0] OFS_TOL_LO = 5'h0A;
  localparam logic [4:0] OFS_PRESC  = 5'h0B;

  localparam logic [7:0]       GLITCH_RST = 8'd3;
  localparam logic [DUR_W-1:0] IDLE_RST   = 16'h00C0;
  localparam logic [DUR_W-1:0] MAXD_RST   = 16'h07D0;
  localparam logic [7:0]       TOL_RST    = 8'h1E;

  typedef enum logic [1:0] {ST_OFF, ST_ARMED, ST_RUN, ST_DONE} cap_state_e;
endpackage

// File: rtl/ir_sample_front.sv
`timescale 1ns/1ps
module ir_sample_front #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GL_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ir_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [GL_W-1:0]  glitch_i,
  output logic             tick_o,
  output logic             level_o
);
  localparam int unsigned GI_W = GL_W + 1;

  logic [DIV_W-1:0] div_cnt_q;
  logic [1:0]       sync_q;
  logic [GL_W-1:0]  gl_cnt_q;
  logic             level_q;
  logic [GL_W-1:0]  gl_need;
  logic [GI_W-1:0]  gl_inc;

  assign tick_o  = (div_cnt_q >= div_i);
  assign gl_need = (glitch_i == '0) ? GL_W'(1) : glitch_i;
  assign gl_inc  = {1'b0, gl_cnt_q} + GI_W'(1);
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      sync_q    <= '0;
      gl_cnt_q  <= '0;
      level_q   <= 1'b0;
    end else begin
      div_cnt_q <= tick_o ? '0 : div_cnt_q + DIV_W'(1);
      sync_q    <= {sync_q[0], ir_i};
      if (tick_o) begin
        if (sync_q[1] != level_q) begin
          // accept only after the new level persisted gl_need ticks
          if (gl_inc >= {1'b0, gl_need}) begin
            level_q  <= sync_q[1];
            gl_cnt_q <= '0;
          end else begin
            gl_cnt_q <= gl_inc[GL_W-1:0];
          end
        end else begin
          gl_cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ir_run_engine.sv
`timescale 1ns/1ps
module ir_run_engine
  import ir_cap_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               level_i,
  input  logic               arm_i,
  input  logic               stop_i,
  input  logic               clr_i,
  input  logic [DUR_W-1:0]   idle_len_i,
  input  logic [DUR_W-1:0]   max_dur_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [ENTRY_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               done_o,
  output logic               ovf_o,
  output logic               nonempty_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  cap_state_e       state_q;
  logic             lvl_q;
  logic [LEN_W-1:0] run_q;
  logic [DUR_W-1:0] total_q, idle_q;
  logic [CNT_W-1:0] count_q;

  logic             running, same, emit, full, end_ovf, end_cap;
  logic [CNT_W-1:0] count_nx;
  logic [DUR_W-1:0] total_nx, idle_nx;

  assign running  = (state_q == ST_RUN) && tick_i;
  assign same     = (level_i == lvl_q);
  assign emit     = running && (!same || run_q == LEN_MAX);
  assign full     = (count_q == FULL_CNT);
  assign wr_en_o  = emit && !full;
  assign wr_addr_o = count_q[ADDR_W-1:0];
  assign wr_data_o = {lvl_q, run_q};
  assign count_nx = wr_en_o ? count_q + CNT_W'(1) : count_q;
  assign total_nx = (total_q == '1) ? total_q : total_q + DUR_W'(1);
  assign idle_nx  = level_i ? '0 : ((idle_q == '1) ? idle_q : idle_q + DUR_W'(1));
  assign end_ovf  = emit && (count_nx == FULL_CNT);
  assign end_cap  = running && (end_ovf || idle_nx >= idle_len_i || total_nx >= max_dur_i);

  assign done_o     = end_cap;
  assign ovf_o      = end_ovf;
  assign nonempty_o = (count_nx != '0);
  assign count_o    = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      lvl_q   <= 1'b0;
      run_q   <= '0;
      total_q <= '0;
      idle_q  <= '0;
      count_q <= '0;
    end else begin
      count_q <= clr_i ? '0 : count_nx;
      if (arm_i) begin
        state_q <= ST_ARMED;
      end else if (stop_i) begin
        state_q <= ST_OFF;
      end else begin
        case (state_q)
          ST_ARMED: if (tick_i && level_i) begin
            state_q <= ST_RUN;
            lvl_q   <= 1'b1;
            run_q   <= LEN_W'(1);
            total_q <= DUR_W'(1);
            idle_q  <= '0;
          end
          ST_RUN: if (tick_i) begin
            if (!same) begin
              lvl_q <= level_i;
              run_q <= LEN_W'(1);
            end else if (run_q == LEN_MAX) begin
              run_q <= LEN_W'(1);
            end else begin
              run_q <= run_q + LEN_W'(1);
            end
            total_q <= total_nx;
            idle_q  <= idle_nx;
            if (end_cap) state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_run_buffer.sv
`timescale 1ns/1ps
module ir_run_buffer #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ir_reg_port.sv
`timescale 1ns/1ps
module ir_reg_port
  import ir_cap_pkg::*;
#(
  parameter int unsigned DEPTH          = 128,
  parameter int unsigned CNT_W          = $clog2(DEPTH + 1),
  parameter logic [7:0]  PRESCALE_RESET = 8'd99
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       buf_data_i,
  input  logic             done_i,
  input  logic             ovf_i,
  input  logic             nonempty_i,
  output logic             arm_o,
  output logic             stop_o,
  output logic             clr_o,
  output logic [7:0]       glitch_o,
  output logic [DUR_W-1:0] idle_len_o,
  output logic [DUR_W-1:0] max_dur_o,
  output logic [7:0]       div_o
);
  logic [2:0]       flag_q;
  logic             en_q;
  logic [7:0]       glitch_q, tol_hi_q, tol_lo_q, div_q;
  logic [DUR_W-1:0] idle_q, maxd_q;
  logic             reg_hit, buf_hit;
  logic [2:0]       flag_nx;

  assign reg_hit = (addr_i[7:5] == 3'b000);
  assign buf_hit = addr_i[7] && ({1'b0, addr_i[6:0]} < 8'(DEPTH));

  function automatic logic wr_at(input logic [4:0] ofs);
    return we_i && reg_hit && (addr_i[4:0] == ofs);
  endfunction

  assign arm_o  = wr_at(OFS_RXCTL) && wdata_i[7];
  assign stop_o = wr_at(OFS_RXCTL) && !wdata_i[7];
  assign clr_o  = wr_at(OFS_BUFCTL) && wdata_i[7];

  always_comb begin
    flag_nx = flag_q;
    if (wr_at(OFS_FLAG)) flag_nx = flag_nx & ~wdata_i[2:0];
    // completion wins over a same-cycle clear
    if (done_i) begin
      flag_nx[0] = 1'b1;
      if (nonempty_i) flag_nx[1] = 1'b1;
      if (ovf_i)      flag_nx[2] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '0;
      en_q     <= 1'b0;
      glitch_q <= GLITCH_RST;
      idle_q   <= IDLE_RST;
      maxd_q   <= MAXD_RST;
      tol_hi_q <= TOL_RST;
      tol_lo_q <= TOL_RST;
      div_q    <= PRESCALE_RESET;
    end else begin
      flag_q <= flag_nx;
      if (wr_at(OFS_RXCTL))  en_q          <= wdata_i[7];
      if (wr_at(OFS_GLITCH)) glitch_q      <= wdata_i;
      if (wr_at(OFS_IDLE_L)) idle_q[7:0]   <= wdata_i;
      if (wr_at(OFS_IDLE_H)) idle_q[15:8]  <= wdata_i;
      if (wr_at(OFS_MAXD_L)) maxd_q[7:0]   <= wdata_i;
      if (wr_at(OFS_MAXD_H)) maxd_q[15:8]  <= wdata_i;
      if (wr_at(OFS_TOL_HI)) tol_hi_q      <= wdata_i;
      if (wr_at(OFS_TOL_LO)) tol_lo_q      <= wdata_i;
      if (wr_at(OFS_PRESC))  div_q         <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i[7]) begin
      if (buf_hit) rdata_o = buf_data_i;
    end else if (reg_hit) begin
      case (addr_i[4:0])
        OFS_FLAG:   rdata_o = {en_q, 4'b0000, flag_q};
        OFS_RXCTL:  rdata_o = {en_q, 7'b0};
        OFS_COUNT:  rdata_o = 8'(count_i);
        OFS_GLITCH: rdata_o = glitch_q;
        OFS_IDLE_L: rdata_o = idle_q[7:0];
        OFS_IDLE_H: rdata_o = idle_q[15:8];
        OFS_MAXD_L: rdata_o = maxd_q[7:0];
        OFS_MAXD_H: rdata_o = maxd_q[15:8];
        OFS_TOL_HI: rdata_o = tol_hi_q;
        OFS_TOL_LO: rdata_o = tol_lo_q;
        OFS_PRESC:  rdata_o = div_q;
        default:    rdata_o = 8'h00;
      endcase
    end
  end

  assign glitch_o   = glitch_q;
  assign idle_len_o = idle_q;
  assign max_dur_o  = maxd_q;
  assign div_o      = div_q;
endmodule

// File: rtl/ir_pulse_capture.sv
`timescale 1ns/1ps
module ir_pulse_capture
  import ir_cap_pkg::*;
#(
  parameter int unsigned DEPTH          = 128,
  parameter logic [7:0]  PRESCALE_RESET = 8'd99
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic [7:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic               smp_tick, smp_level;
  logic [7:0]         div_val, glitch_val, buf_rdata;
  logic [DUR_W-1:0]   idle_len, max_dur;
  logic               arm, stop, clr, done, ovf, nonempty;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [ENTRY_W-1:0] wr_data;
  logic [CNT_W-1:0]   count;

  ir_sample_front #(.DIV_W(8), .GL_W(8)) u_front (
    .clk_i, .rst_ni, .ir_i,
    .div_i(div_val), .glitch_i(glitch_val),
    .tick_o(smp_tick), .level_o(smp_level)
  );

  ir_run_engine #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni,
    .tick_i(smp_tick), .level_i(smp_level),
    .arm_i(arm), .stop_i(stop), .clr_i(clr),
    .idle_len_i(idle_len), .max_dur_i(max_dur),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .count_o(count), .done_o(done), .ovf_o(ovf), .nonempty_o(nonempty)
  );

  ir_run_buffer #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .ADDR_W(ADDR_W)) u_buf (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(reg_addr_i[ADDR_W-1:0]), .rdata_o(buf_rdata)
  );

  ir_reg_port #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PRESCALE_RESET(PRESCALE_RESET)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .count_i(count), .buf_data_i(buf_rdata),
    .done_i(done), .ovf_i(ovf), .nonempty_i(nonempty),
    .arm_o(arm), .stop_o(stop), .clr_o(clr),
    .glitch_o(glitch_val), .idle_len_o(idle_len), .max_dur_o(max_dur), .div_o(div_val)
  );
endmodule

// File: rtl/ir_pulse_capture_chk.sv
`timescale 1ns/1ps
module ir_pulse_capture_chk #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [7:0]       div_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic [CNT_W-1:0] count_i,
  input logic             clr_i,
  input logic             done_i,
  input logic             ovf_i,
  input logic [7:0]       reg_addr_i,
  input logic [7:0]       reg_rdata_i
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  a_r1_write_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> tick_i);

  a_r2_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_data_i[6:0] != 7'd0));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= FULL_CNT);

  a_r6_ovf_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> done_i);

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (count_i == $past(count_i)) || (count_i == $past(count_i) + CNT_W'(1)));

  a_r8_clear_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_i == '0));

  a_r7_done_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_i) && reg_addr_i == 8'h00) |-> reg_rdata_i[0]);

  a_r10_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != 8'd0) |=> (!tick_i || div_i == 8'd0));
endmodule

bind ir_pulse_capture ir_pulse_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tick_i(smp_tick), .div_i(div_val),
  .wr_en_i(wr_en), .wr_data_i(wr_data), .count_i(count),
  .clr_i(clr), .done_i(done), .ovf_i(ovf),
  .reg_addr_i(reg_addr_i), .reg_rdata_i(reg_rdata_o)
);

// File: tb/ir_pulse_capture_test.sv
`timescale 1ns/1ps
module ir_pulse_capture_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int vectors = 0;
  int miscmp = 0;
  int tpc = 2;        // clocks per sample tick
  int glitch = 3;
  int idle_len = 192;
  int max_dur = 2000;
  int exp_q[$];
  bit exp_ovf;

  always #5 clk = ~clk;

  ir_pulse_capture #(.DEPTH(DEPTH), .PRESCALE_RESET(8'd1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    addr = 8'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(negedge clk);
    addr = 8'(a);
    #1 d = int'(rdata);
  endtask

  task automatic expect_reg(input string tag, input int a, input int exp);
    int v;
    reg_rd(a, v);
    check(tag, v, exp);
  endtask

  // behavioural model: per-tick line, glitch filter, run recorder
  task automatic model(input int runs[$]);
    int s[$];
    int f, c, need, lvl, rl, tot, idl;
    bit started, emit;
    lvl = 1;
    foreach (runs[i]) begin
      repeat (runs[i]) s.push_back(lvl);
      lvl ^= 1;
    end
    repeat (3000) s.push_back(0);
    exp_q.delete();
    exp_ovf = 0;
    f = 0; c = 0; need = (glitch == 0) ? 1 : glitch;
    started = 0; lvl = 0; rl = 0; tot = 0; idl = 0;
    foreach (s[i]) begin
      if (s[i] != f) begin
        c++;
        if (c >= need) begin f = s[i]; c = 0; end
      end else c = 0;
      if (!started) begin
        if (f == 1) begin started = 1; lvl = 1; rl = 1; tot = 1; idl = 0; end
        continue;
      end
      emit = (f != lvl) || (rl == 127);
      if (emit && exp_q.size() < DEPTH) exp_q.push_back(lvl * 128 + rl);
      if (f != lvl) begin lvl = f; rl = 1; end
      else if (rl == 127) rl = 1;
      else rl++;
      tot++;
      idl = (f == 0) ? idl + 1 : 0;
      if (emit && exp_q.size() == DEPTH) begin exp_ovf = 1; break; end
      if (idl >= idle_len || tot >= max_dur) break;
    end
  endtask

  task automatic play(input int runs[$]);
    int l = 1;
    foreach (runs[i]) begin
      ir = l[0];
      repeat (runs[i] * tpc) @(negedge clk);
      l ^= 1;
    end
    ir = 1'b0;
  endtask

  task automatic rearm(input int clr_bits);
    reg_wr(8'h00, clr_bits);
    reg_wr(8'h02, 8'h80);
    reg_wr(8'h01, 8'h80);
  endtask

  task automatic capture(input string tag, input int runs[$]);
    int v;
    bit seen = 0;
    model(runs);
    play(runs);
    addr = 8'h00;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      #1 if (rdata[0]) seen = 1;
    end
    check({tag, " completion seen"}, int'(seen), 1);
    expect_reg({tag, " R7 flag"}, 8'h00,
               8'h81 | ((exp_q.size() != 0) ? 2 : 0) | (exp_ovf ? 4 : 0));
    expect_reg({tag, " R11 count"}, 8'h03, exp_q.size());
    foreach (exp_q[i]) expect_reg({tag, " R1 entry"}, 8'h80 + i, exp_q[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state and defaults
    expect_reg("R12 flag at reset", 8'h00, 8'h00);
    expect_reg("R12 count at reset", 8'h03, 0);
    expect_reg("R9 glitch default", 8'h04, 3);
    expect_reg("R9 idle lo default", 8'h05, 8'hC0);
    expect_reg("R9 idle hi default", 8'h06, 8'h00);
    expect_reg("R9 max lo default", 8'h07, 8'hD0);
    expect_reg("R9 max hi default", 8'h08, 8'h07);
    expect_reg("R9 tol hi default", 8'h09, 8'h1E);
    expect_reg("R9 tol lo default", 8'h0A, 8'h1E);
    expect_reg("R9 prescaler default", 8'h0B, 1);

    // R12: unarmed engine ignores the line
    play('{8, 8, 8});
    repeat (100) @(negedge clk);
    expect_reg("R12 no capture before arm", 8'h00, 8'h00);
    expect_reg("R12 count before arm", 8'h03, 0);

    reg_wr(8'h05, 40); reg_wr(8'h06, 0); idle_len = 40;
    expect_reg("R9 idle lo readback", 8'h05, 40);
    reg_wr(8'h09, 8'h22);
    expect_reg("R9 tol hi readback", 8'h09, 8'h22);

    // R1 R4 basic capture ending on idle
    rearm(8'h07);
    capture("R4 idle end", '{10, 6, 20, 8, 4});

    // R7 write-one-to-clear, per bit
    reg_wr(8'h00, 8'h01);
    expect_reg("R7 clear bit0 only", 8'h00, 8'h82);
    reg_wr(8'h00, 8'h02);
    expect_reg("R7 clear bit1", 8'h00, 8'h80);
    reg_wr(8'h02, 8'h80);
    expect_reg("R8 buffer clear", 8'h03, 0);
    reg_wr(8'h01, 8'h80);

    // R2 saturation
    capture("R2 saturation", '{300, 10, 5});

    // R3 glitch merge with default length 3
    rearm(8'h03);
    capture("R3 glitch merge", '{10, 2, 10, 1, 8, 12, 6});

    // R3 glitch length 0 acts as 1
    reg_wr(8'h04, 0); glitch = 0;
    rearm(8'h03);
    capture("R3 glitch zero", '{3, 1, 2});
    reg_wr(8'h04, 3); glitch = 3;

    // R5 maximum duration
    reg_wr(8'h07, 50); reg_wr(8'h08, 0); max_dur = 50;
    rearm(8'h03);
    capture("R5 max end", '{20, 20, 30});
    rearm(8'h03);
    capture("R5 max inside pulse", '{200});
    reg_wr(8'h07, 8'hD0); reg_wr(8'h08, 8'h07); max_dur = 2000;

    // R6 overflow
    rearm(8'h03);
    capture("R6 overflow", '{5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5,5});
    expect_reg("R11 window beyond depth", 8'h80 + 20, 0);

    // R8 stop: capture disabled ignores the line
    rearm(8'h07);
    reg_wr(8'h01, 8'h00);
    play('{10, 10, 10});
    repeat (200) @(negedge clk);
    expect_reg("R8 stopped flag", 8'h00, 8'h00);
    expect_reg("R8 stopped count", 8'h03, 0);

    // R10 prescaler rewrite
    reg_wr(8'h0B, 3); tpc = 4;
    expect_reg("R10 prescaler readback", 8'h0B, 3);
    rearm(8'h03);
    capture("R10 slower tick", '{7, 9, 3});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule